// File: doc/BRIEF.md
# Program-Memory Write Gate and I/O Window Decoder

This block sits on the data-side bus of a core whose code and data live in separate memories. It splits each data access in two ways. Ordinary accesses pass straight through to the data RAM port. Accesses that land in a small I/O window are decoded into a few device functions. The most important of these is a guarded path for writing instruction memory. Software must first store a 32-bit key. It then sets a hardware pointer and streams data words through one data register. Each accepted word goes out on the program-memory write port, and the pointer then advances by four.

The window also has a console byte output, a console byte input, a coarse cycle timer that counts one tick per hundred clocks, an exit strobe and a debug strobe. It flags reads of addresses that nothing answers. An optional flag reports writes to I/O addresses that nothing decodes. The RAM and program-memory arrays are outside the block and are reached through plain ports.

Top module: `pmem_io_gate`

## Requirements
- R1: Only the low 17 bits of `bus_addr` are used. Bit 16 set selects the I/O window. Bit 16 clear drives `ram_wr_en`/`ram_rd_en` in the same cycle with `ram_addr` = aligned bits 15:0. No I/O function reacts to such an access.
- R2: The size code is 0 = byte, 1 = halfword, 2 = word, and 3 is treated like a byte. Size 1 clears address bit 0. Size 2 clears bits 1:0. This applies to `ram_addr` and to `pm_addr`.
- R3: A write to offset 0x1FC80 unlocks the program-memory path only when the data equals 0x1337F7D1. Any other value written there locks it. After reset the path is locked and the pointer is zero.
- R4: A write to offset 0x1FC84 loads the pointer with the low PM_AW bits of the data. While the path is unlocked, a write to 0x1FC88 pulses `pm_wr_en` for one cycle after the bus cycle. That pulse carries the aligned pointer, the size and the data, and the pointer then advances by 4.
- R5: While the path is locked, a write to 0x1FC88 produces no `pm_wr_en` and leaves the pointer unchanged.
- R6: A write to 0x10000 pulses `con_valid` for one cycle after the bus cycle, with `con_byte` = data bits 7:0.
- R7: A read of 0x1FFF4 returns, on `bus_rdata` in the same cycle, the number of clock edges since reset release divided by 100 and rounded down.
- R8: A read of 0x10000 returns `con_in` zero-extended. A read outside the window returns `ram_rdata`.
- R9: A read of any other I/O address pulses `illegal_rd` for one cycle after the bus cycle. Reads of 0x10000 and 0x1FFF4 never raise it.
- R10: A write to 0x1FFFC pulses `exit_pulse`. A write to 0x1FFF8 pulses `dbg_valid` with `dbg_data` = data. Both pulses come one cycle after the bus cycle.
- R11: A write to an undecoded I/O address pulses `unknown_wr` for one cycle and raises no other strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Data-bus write request |
| bus_rd_en | input | 1 | Data-bus read request |
| bus_addr | input | 32 | Data-bus byte address |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| ram_wr_en | output | 1 | Data RAM write enable |
| ram_rd_en | output | 1 | Data RAM read enable |
| ram_addr | output | RAM_AW | Aligned data RAM address |
| ram_size | output | 2 | Size code forwarded to RAM |
| ram_wdata | output | 32 | Write data forwarded to RAM |
| ram_rdata | input | 32 | Data RAM read data |
| pm_wr_en | output | 1 | Program-memory write strobe |
| pm_addr | output | PM_AW | Aligned program-memory address |
| pm_size | output | 2 | Program-memory write size code |
| pm_wdata | output | 32 | Program-memory write data |
| con_valid | output | 1 | Console output byte valid |
| con_byte | output | 8 | Console output byte |
| con_in | input | 8 | Console input byte |
| exit_pulse | output | 1 | Exit request strobe |
| dbg_valid | output | 1 | Debug word strobe |
| dbg_data | output | 32 | Debug word |
| illegal_rd | output | 1 | Read of an unanswered I/O address |
| unknown_wr | output | 1 | Write to an undecoded I/O address |

## Verification
The RAM path is swept over every low-address pattern from 0 to 7 under each size code. This separates correct bit clearing from clearing one bit too many or too few. The program-memory path runs a key, pointer and data sequence. It writes first after reset, then with a wrong key, then with the key again, and then with halfword and byte sizes. A dropped write shows up as an unchanged address on the next accepted write, and the step of four shows up against the alignment. The timer is read on every cycle across two tick boundaries, which exposes an off-by-one in the prescaler. The remaining I/O offsets are each hit once, with upper address bits set to show that only the low 17 bits matter.

// File: rtl/pmio_pkg.sv
package pmio_pkg;

   // Offsets inside the I/O window (low 16 bits; bit 16 marks the window)
   localparam logic [15:0] WIN_CONSOLE = 16'h0000;
   localparam logic [15:0] WIN_PM_KEY  = 16'hFC80;
   localparam logic [15:0] WIN_PM_PTR  = 16'hFC84;
   localparam logic [15:0] WIN_PM_DATA = 16'hFC88;
   localparam logic [15:0] WIN_TIMER   = 16'hFFF4;
   localparam logic [15:0] WIN_DEBUG   = 16'hFFF8;
   localparam logic [15:0] WIN_EXIT    = 16'hFFFC;

   typedef enum logic [2:0] {
      IO_NONE, IO_CONSOLE, IO_PM_KEY, IO_PM_PTR,
      IO_PM_DATA, IO_TIMER, IO_DEBUG, IO_EXIT
   } io_sel_e;

   // Low address bits to clear for a given size code
   function automatic logic [1:0] low_clear(input logic [1:0] size);
      case (size)
         2'd1:    low_clear = 2'b01;
         2'd2:    low_clear = 2'b11;
         default: low_clear = 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/pmio_decode.sv
module pmio_decode
   import pmio_pkg::*;
#(
   parameter int RAM_AW = 16
) (
   input  logic [RAM_AW:0]   addr,
   input  logic [1:0]        size,
   output logic              is_io,
   output logic [RAM_AW-1:0] ram_addr,
   output io_sel_e           sel
);

   logic [RAM_AW-1:0] low;

   assign low      = addr[RAM_AW-1:0];
   assign is_io    = addr[RAM_AW];
   assign ram_addr = {low[RAM_AW-1:2], low[1:0] & ~low_clear(size)};

   always_comb begin
      sel = IO_NONE;
      if      (low == RAM_AW'(WIN_CONSOLE)) sel = IO_CONSOLE;
      else if (low == RAM_AW'(WIN_PM_KEY))  sel = IO_PM_KEY;
      else if (low == RAM_AW'(WIN_PM_PTR))  sel = IO_PM_PTR;
      else if (low == RAM_AW'(WIN_PM_DATA)) sel = IO_PM_DATA;
      else if (low == RAM_AW'(WIN_TIMER))   sel = IO_TIMER;
      else if (low == RAM_AW'(WIN_DEBUG))   sel = IO_DEBUG;
      else if (low == RAM_AW'(WIN_EXIT))    sel = IO_EXIT;
   end

endmodule

// File: rtl/pmio_pmport.sv
module pmio_pmport
   import pmio_pkg::*;
#(
   parameter int          PM_AW = 18,
   parameter logic [31:0] KEY   = 32'h1337F7D1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_we,
   input  logic             ptr_we,
   input  logic             data_we,
   input  logic [31:0]      wdata,
   input  logic [1:0]       size,
   output logic             pm_wr_en,
   output logic [PM_AW-1:0] pm_addr,
   output logic [1:0]       pm_size,
   output logic [31:0]      pm_wdata
);

   localparam logic [PM_AW-1:0] STEP = PM_AW'(4);

   logic             unlocked_q;
   logic [PM_AW-1:0] ptr_q;
   logic             accept;

   assign accept = data_we && unlocked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked_q <= 1'b0;
         ptr_q      <= '0;
         pm_wr_en   <= 1'b0;
         pm_addr    <= '0;
         pm_size    <= '0;
         pm_wdata   <= '0;
      end else begin
         if (key_we) unlocked_q <= (wdata == KEY);
         if (ptr_we)      ptr_q <= wdata[PM_AW-1:0];
         else if (accept) ptr_q <= ptr_q + STEP;
         pm_wr_en <= accept;
         if (accept) begin
            pm_addr  <= {ptr_q[PM_AW-1:2], ptr_q[1:0] & ~low_clear(size)};
            pm_size  <= size;
            pm_wdata <= wdata;
         end
      end
   end

   AST_PM_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      pm_wr_en |-> $past(unlocked_q)); // R5

   AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      pm_wr_en |-> ptr_q == $past(ptr_q) + STEP); // R4

   AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(data_we && !unlocked_q && !ptr_we) |-> ptr_q == $past(ptr_q)); // R5

endmodule

// File: rtl/pmio_tick.sv
module pmio_tick #(
   parameter int DIV = 100
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic [31:0] count
);

   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         count <= '0;
      end else if (pre_q == LAST) begin
         pre_q <= '0;
         count <= count + 32'd1;
      end else begin
         pre_q <= pre_q + PW'(1);
      end
   end

   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> (count == $past(count) + 32'd1 && pre_q == '0)); // R7

endmodule

// File: rtl/pmem_io_gate.sv
module pmem_io_gate
   import pmio_pkg::*;
#(
   parameter int          RAM_AW          = 16,
   parameter int          PM_AW           = 18,
   parameter int          TICK_DIV        = 100,
   parameter bit          UNKNOWN_FLAG_EN = 1'b1,
   parameter logic [31:0] UNLOCK_KEY      = 32'h1337F7D1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic              bus_rd_en,
   input  logic [31:0]       bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              ram_wr_en,
   output logic              ram_rd_en,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [1:0]        ram_size,
   output logic [31:0]       ram_wdata,
   input  logic [31:0]       ram_rdata,
   output logic              pm_wr_en,
   output logic [PM_AW-1:0]  pm_addr,
   output logic [1:0]        pm_size,
   output logic [31:0]       pm_wdata,
   output logic              con_valid,
   output logic [7:0]        con_byte,
   input  logic [7:0]        con_in,
   output logic              exit_pulse,
   output logic              dbg_valid,
   output logic [31:0]       dbg_data,
   output logic              illegal_rd,
   output logic              unknown_wr
);

   if (RAM_AW != 16) begin : g_bad_ram_aw
      $error("RAM_AW must be 16: the I/O window offsets use 16 bits");
   end
   if (PM_AW < 3 || PM_AW > 32) begin : g_bad_pm_aw
      $error("PM_AW must lie in 3..32");
   end
   if (TICK_DIV < 2) begin : g_bad_div
      $error("TICK_DIV must be at least 2");
   end

   logic        is_io;
   io_sel_e     sel;
   logic        io_wr, io_rd;
   logic [31:0] tick_count;
   logic        unused_hi;

   assign unused_hi = ^bus_addr[31:RAM_AW+1];

   pmio_decode #(.RAM_AW(RAM_AW)) u_decode (
      .addr     (bus_addr[RAM_AW:0]),
      .size     (bus_size),
      .is_io    (is_io),
      .ram_addr (ram_addr),
      .sel      (sel)
   );

   assign io_wr     = bus_wr_en &&  is_io;
   assign io_rd     = bus_rd_en &&  is_io;
   assign ram_wr_en = bus_wr_en && !is_io;
   assign ram_rd_en = bus_rd_en && !is_io;
   assign ram_size  = bus_size;
   assign ram_wdata = bus_wdata;

   pmio_pmport #(.PM_AW(PM_AW), .KEY(UNLOCK_KEY)) u_pmport (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_we   (io_wr && sel == IO_PM_KEY),
      .ptr_we   (io_wr && sel == IO_PM_PTR),
      .data_we  (io_wr && sel == IO_PM_DATA),
      .wdata    (bus_wdata),
      .size     (bus_size),
      .pm_wr_en (pm_wr_en),
      .pm_addr  (pm_addr),
      .pm_size  (pm_size),
      .pm_wdata (pm_wdata)
   );

   pmio_tick #(.DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .count (tick_count)
   );

   always_comb begin
      if (!is_io)                bus_rdata = ram_rdata;
      else if (sel == IO_CONSOLE) bus_rdata = {24'd0, con_in};
      else if (sel == IO_TIMER)   bus_rdata = tick_count;
      else                        bus_rdata = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         con_valid  <= 1'b0;
         con_byte   <= '0;
         exit_pulse <= 1'b0;
         dbg_valid  <= 1'b0;
         dbg_data   <= '0;
         illegal_rd <= 1'b0;
      end else begin
         con_valid  <= io_wr && sel == IO_CONSOLE;
         if (io_wr && sel == IO_CONSOLE) con_byte <= bus_wdata[7:0];
         exit_pulse <= io_wr && sel == IO_EXIT;
         dbg_valid  <= io_wr && sel == IO_DEBUG;
         if (io_wr && sel == IO_DEBUG) dbg_data <= bus_wdata;
         illegal_rd <= io_rd && !(sel == IO_CONSOLE || sel == IO_TIMER);
      end
   end

   if (UNKNOWN_FLAG_EN) begin : g_unknown_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) unknown_wr <= 1'b0;
         else        unknown_wr <= io_wr && sel == IO_NONE;
      end
   end else begin : g_no_unknown_flag
      assign unknown_wr = 1'b0;
   end

   AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      ((ram_wr_en || ram_rd_en) && ram_size == 2'd2) |-> ram_addr[1:0] == 2'b00); // R2

   AST_CON_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      con_valid |-> $past(bus_wr_en) && $past(bus_addr[RAM_AW])); // R6

   AST_ILLEGAL_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_rd |-> $past(bus_rd_en) && $past(bus_addr[RAM_AW])); // R9

endmodule

// File: tb/test_pmem_io_gate.sv
`timescale 1ns/1ps
module test_pmem_io_gate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
   logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
   logic [1:0]  bus_size = '0;
   logic        ram_wr_en, ram_rd_en;
   logic [15:0] ram_addr;
   logic [1:0]  ram_size, pm_size;
   logic [31:0] ram_wdata, ram_rdata = 32'hCAFEF00D;
   logic        pm_wr_en;
   logic [17:0] pm_addr;
   logic [31:0] pm_wdata;
   logic        con_valid;
   logic [7:0]  con_byte, con_in = 8'h5C;
   logic        exit_pulse, dbg_valid, illegal_rd, unknown_wr;
   logic [31:0] dbg_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [31:0] rd_val;

   always #4 clk = ~clk;
   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   pmem_io_gate i_pmem_io_gate (
      .clk, .rst_n, .bus_wr_en, .bus_rd_en, .bus_addr, .bus_size, .bus_wdata,
      .bus_rdata, .ram_wr_en, .ram_rd_en, .ram_addr, .ram_size, .ram_wdata,
      .ram_rdata, .pm_wr_en, .pm_addr, .pm_size, .pm_wdata, .con_valid,
      .con_byte, .con_in, .exit_pulse, .dbg_valid, .dbg_data, .illegal_rd,
      .unknown_wr
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [31:0] a);
      @(negedge clk);
      bus_rd_en = 1'b1; bus_addr = a; bus_size = 2'd2;
      #1 rd_val = bus_rdata;
      @(negedge clk);
      bus_rd_en = 1'b0;
   endtask

   function automatic logic [31:0] strobes();
      return {27'd0, pm_wr_en, con_valid, exit_pulse, dbg_valid, unknown_wr};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state, R3
      chk("R3 reset strobes", strobes(), 32'd0);
      chk("R3 reset illegal", {31'd0, illegal_rd}, 32'd0);

      // R1 / R2: RAM path sweep over low bits and sizes
      for (int s = 0; s < 3; s++) begin
         for (int lo = 0; lo < 8; lo++) begin
            logic [31:0] a;
            logic [15:0] e;
            a = 32'h5A5A_0120 | lo;
            e = 16'h0120 | lo;
            if (s == 1) e[0] = 1'b0;
            if (s == 2) e[1:0] = 2'b00;
            @(negedge clk);
            bus_wr_en = 1'b1; bus_addr = a; bus_size = 2'(s); bus_wdata = 32'h1111_0000 + lo;
            #1;
            chk("R1 ram_wr_en", {31'd0, ram_wr_en}, 32'd1);
            chk("R2 ram_addr align", {16'd0, ram_addr}, {16'd0, e});
            chk("R1 ram_wdata", ram_wdata, 32'h1111_0000 + lo);
         end
      end
      @(negedge clk);
      bus_wr_en = 1'b0;
      chk("R1 ram write gives no io strobe", strobes(), 32'd0);

      // R8: RAM read and console input read
      bus_read(32'hFF00_0040);
      chk("R8 ram read data", rd_val, 32'hCAFEF00D);
      chk("R9 ram read no illegal", {31'd0, illegal_rd}, 32'd0);
      bus_read(32'h0001_0000);
      chk("R8 console in", rd_val, 32'h0000_005C);
      chk("R9 console read no illegal", {31'd0, illegal_rd}, 32'd0);

      // R3/R4: unlock, first write uses reset pointer zero
      bus_write(32'hFFFF_FC80, 2'd2, 32'h1337F7D1);
      bus_write(32'hFFFF_FC88, 2'd2, 32'hA0A0_0001);
      chk("R4 pm_wr_en after unlock", {31'd0, pm_wr_en}, 32'd1);
      chk("R3 pm_addr from reset pointer", {14'd0, pm_addr}, 32'd0);
      chk("R4 pm_wdata", pm_wdata, 32'hA0A0_0001);
      @(negedge clk);
      chk("R4 pm_wr_en one cycle", {31'd0, pm_wr_en}, 32'd0);

      // R3/R5: wrong key locks, write dropped, pointer kept
      bus_write(32'h0001_FC84, 2'd2, 32'h0000_0100);
      bus_write(32'h0001_FC80, 2'd2, 32'h1337F7D0);
      bus_write(32'h0001_FC88, 2'd2, 32'hDEAD_0002);
      chk("R5 locked write dropped", {31'd0, pm_wr_en}, 32'd0);
      bus_write(32'h0001_FC80, 2'd2, 32'h1337F7D1);
      bus_write(32'h0001_FC88, 2'd2, 32'hB0B0_0003);
      chk("R5 pointer unchanged by dropped write", {14'd0, pm_addr}, 32'h100);
      bus_write(32'h0001_FC88, 2'd2, 32'hB0B0_0004);
      chk("R4 pointer step 4", {14'd0, pm_addr}, 32'h104);

      // R2/R4: sized program-memory writes
      bus_write(32'h0001_FC84, 2'd2, 32'h0000_0203);
      bus_write(32'h0001_FC88, 2'd1, 32'h0000_BEEF);
      chk("R2 pm halfword align", {14'd0, pm_addr}, 32'h202);
      chk("R4 pm_size", {30'd0, pm_size}, 32'd1);
      bus_write(32'h0001_FC88, 2'd2, 32'h1234_5678);
      chk("R2 pm word align", {14'd0, pm_addr}, 32'h204);
      bus_write(32'h0001_FC88, 2'd0, 32'h0000_0077);
      chk("R2 pm byte no align", {14'd0, pm_addr}, 32'h20B);

      // R6 console output
      bus_write(32'hABCD_0000, 2'd0, 32'h1234_56A5);
      chk("R6 con_valid", {31'd0, con_valid}, 32'd1);
      chk("R6 con_byte", {24'd0, con_byte}, 32'hA5);
      @(negedge clk);
      chk("R6 con_valid one cycle", {31'd0, con_valid}, 32'd0);

      // R10 exit and debug
      bus_write(32'h0001_FFFC, 2'd2, 32'd0);
      chk("R10 exit strobe", strobes(), 32'b00100);
      bus_write(32'h0001_FFF8, 2'd2, 32'h0BAD_F00D);
      chk("R10 debug strobe", strobes(), 32'b00010);
      chk("R10 debug data", dbg_data, 32'h0BAD_F00D);

      // R11 unknown write
      bus_write(32'h0001_F000, 2'd2, 32'h5555_5555);
      chk("R11 unknown only", strobes(), 32'b00001);
      @(negedge clk);
      chk("R11 unknown one cycle", strobes(), 32'd0);

      // R9 illegal reads
      bus_read(32'h0001_FF00);
      chk("R9 illegal read flag", {31'd0, illegal_rd}, 32'd1);
      bus_read(32'h0001_FC80);
      chk("R9 key offset read illegal", {31'd0, illegal_rd}, 32'd1);
      bus_read(32'h0001_FFF4);
      chk("R9 timer read legal", {31'd0, illegal_rd}, 32'd0);

      // R7 timer across tick boundaries
      @(negedge clk);
      bus_rd_en = 1'b1; bus_addr = 32'h0001_FFF4; bus_size = 2'd2;
      for (int k = 0; k < 250; k++) begin
         @(negedge clk);
         chk("R7 timer", bus_rdata, 32'(cyc / 100));
      end
      bus_rd_en = 1'b0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule